// File: doc/BRIEF.md
# Audio Clock Regeneration Value Selector

This block supplies the numerator (N) and time-stamp (CTS) values that an audio clock regeneration packet carries. It has two ways to get them. A lookup strobe takes a pixel clock rate, given in kHz, and chooses a pair from a fixed rate table. Software can also load an arbitrary pair through a small byte-wide register bank.

Writes through the bank first go to shadow storage. The committed outputs change only at one point: a write to the N low byte made while an arm flag is set. At that write both values move in the same cycle, so a downstream consumer never sees an N from one pair next to a CTS from another. A valid flag marks a committed pair that is ready for use. An unsupported flag marks a pixel rate that the table does not cover.

Top module: `acr_ncts_sel`

## Requirements
- R1: While reset is asserted and after it is released, `n_out` and `cts_out` read 0, and `valid` and `unsupported` read 0.
- R2: A `lookup_stb` cycle whose `pix_khz` is at or below 297000 loads the pair for the lowest table rate that is greater than or equal to `pix_khz`. The table rates are 25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000, 74176, 74250, 83500, 106500, 108000, 148352, 148500 and 297000 kHz. The pair appears on the outputs at the clock edge that samples the strobe, and `unsupported` is cleared at that same edge.
- R3: Each table rate uses N = 6144 and CTS = the rate in kHz, with three exceptions. 74176 kHz uses N = 11648 and CTS = 140625. 148352 kHz uses N = 5824 and CTS = 140625. 297000 kHz uses N = 5120 and CTS = 247500.
- R4: A `lookup_stb` cycle with `pix_khz` above 297000 sets `unsupported` and leaves `n_out` and `cts_out` unchanged. Any later commit clears `unsupported`.
- R5: The register map, by `wr_addr`, is as follows.
  - 0 holds CTS[19:16] in data bits 3:0. Data bits 7:4 are accepted and have no effect.
  - 1 holds CTS[15:8], and 2 holds CTS[7:0].
  - 3 holds N[19:16] in bits 3:0 and the arm flag in bit 7.
  - 4 holds N[15:8], and 5 holds N[7:0].
  - Writes to addresses 6 and 7 have no effect.
- R6: Writes to addresses 0 to 4 do not change the outputs. A write to address 5 while armed loads the whole staged pair, with the written byte as N[7:0], at that edge, and it clears the arm flag.
- R7: A write to address 5 while not armed leaves `n_out` and `cts_out` unchanged.
- R8: `valid` rises one clock after the edge of any commit, whether from a lookup or a write. A write to address 0 clears it at its own edge, and that clear takes priority over a pending rise.
- R9: A lookup that hits in the same cycle as an armed address-5 write wins. The outputs take the table pair, and the write is dropped while the arm flag is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_khz | input | FREQ_W | Pixel clock rate in kHz |
| lookup_stb | input | 1 | Selects a pair from the table for `pix_khz` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write byte |
| n_out | output | 20 | Committed N |
| cts_out | output | 20 | Committed CTS |
| valid | output | 1 | The committed pair is ready |
| unsupported | output | 1 | The last lookup rate is beyond the table |

## Verification
The bench aims at the table edges.
- It tests each rate exactly and one kHz above it. A `<` comparison where `<=` belongs would shift the choice one entry up.
- It tests 297000 against 297001. A design that wrapped the index or clamped to the last entry would load a pair there instead of raising `unsupported`.
- It checks the three exception pairs. A rule-only table would give 6144/kHz for those rates.

The byte sequence is checked for early visibility. A design without the gate would show half-written values at the outputs. The same checks cover an unarmed low-byte write, stray addresses 6 and 7, and the lookup-versus-write collision. The timing of `valid` is checked so that a flag raised at the commit edge, or a flag left high through a new sequence, is caught.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int ACR_W   = 20;
  localparam int HI_W    = ACR_W - 16;
  localparam int TBL_N   = 16;
  localparam int IDX_W   = $clog2(TBL_N + 1);
  localparam int REG_AW  = 3;
  localparam int ARM_BIT = 7;
  localparam int unsigned TOP_KHZ = 297000;

  typedef struct packed {
    logic [ACR_W-1:0] n;
    logic [ACR_W-1:0] cts;
  } acr_pair_t;

  typedef enum logic [REG_AW-1:0] {
    RA_CTS_HI  = 3'd0,
    RA_CTS_MID = 3'd1,
    RA_CTS_LO  = 3'd2,
    RA_N_HI    = 3'd3,
    RA_N_MID   = 3'd4,
    RA_N_LO    = 3'd5
  } acr_reg_e;

  // ascending rate thresholds in kHz
  function automatic int unsigned ent_khz(input int idx);
    case (idx)
      0:  return 25175;
      1:  return 25200;
      2:  return 27000;
      3:  return 27027;
      4:  return 40000;
      5:  return 54000;
      6:  return 54054;
      7:  return 65000;
      8:  return 74176;
      9:  return 74250;
      10: return 83500;
      11: return 106500;
      12: return 108000;
      13: return 148352;
      14: return 148500;
      15: return TOP_KHZ;
      default: return 0;
    endcase
  endfunction

  // default rule N=6144, CTS=kHz; three fractional-rate exceptions
  function automatic acr_pair_t ent_pair(input int idx);
    acr_pair_t p;
    p.n   = ACR_W'(6144);
    p.cts = ACR_W'(ent_khz(idx));
    case (idx)
      8:  begin p.n = ACR_W'(11648); p.cts = ACR_W'(140625); end
      13: begin p.n = ACR_W'(5824);  p.cts = ACR_W'(140625); end
      15: begin p.n = ACR_W'(5120);  p.cts = ACR_W'(247500); end
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/acr_rate_lut.sv
module acr_rate_lut
  import acr_pkg::*;
#(
  parameter int FREQ_W = 20
) (
  input  logic [FREQ_W-1:0] pix_khz,
  output logic              hit,
  output acr_pair_t         pair
);
  logic [TBL_N-1:0] below;
  logic [IDX_W-1:0] idx;

  // one comparator per entry; the count of entries below the rate is the index
  for (genvar g = 0; g < TBL_N; g++) begin : g_cmp
    assign below[g] = 32'(pix_khz) > 32'(ent_khz(g));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < TBL_N; i++) idx = idx + IDX_W'(below[i]);
    hit  = idx < IDX_W'(TBL_N);
    pair = ent_pair(int'(idx));
  end
endmodule

// File: rtl/acr_shadow_bank.sv
module acr_shadow_bank
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output acr_pair_t         wr_pair,
  output logic              commit,
  output logic              seq_start
);
  logic [HI_W-1:0] cts_hi_q, cts_hi_d, n_hi_q, n_hi_d;
  logic [7:0]      cts_mid_q, cts_mid_d, cts_lo_q, cts_lo_d, n_mid_q, n_mid_d;
  logic            arm_q, arm_d;
  logic            lo_wr;

  assign lo_wr     = wr_en && (wr_addr == RA_N_LO);
  assign commit    = lo_wr && arm_q;
  assign seq_start = wr_en && (wr_addr == RA_CTS_HI);
  // low N byte bypasses the shadow and is taken from the bus at commit
  assign wr_pair.n   = {n_hi_q, n_mid_q, wr_data};
  assign wr_pair.cts = {cts_hi_q, cts_mid_q, cts_lo_q};

  always_comb begin
    cts_hi_d  = cts_hi_q;
    cts_mid_d = cts_mid_q;
    cts_lo_d  = cts_lo_q;
    n_hi_d    = n_hi_q;
    n_mid_d   = n_mid_q;
    arm_d     = arm_q;
    if (wr_en) begin
      case (wr_addr)
        RA_CTS_HI:  cts_hi_d  = wr_data[HI_W-1:0];
        RA_CTS_MID: cts_mid_d = wr_data;
        RA_CTS_LO:  cts_lo_d  = wr_data;
        RA_N_HI: begin
          n_hi_d = wr_data[HI_W-1:0];
          arm_d  = wr_data[ARM_BIT];
        end
        RA_N_MID:   n_mid_d   = wr_data;
        RA_N_LO:    arm_d     = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_hi_q  <= '0;
      cts_mid_q <= '0;
      cts_lo_q  <= '0;
      n_hi_q    <= '0;
      n_mid_q   <= '0;
      arm_q     <= 1'b0;
    end else begin
      cts_hi_q  <= cts_hi_d;
      cts_mid_q <= cts_mid_d;
      cts_lo_q  <= cts_lo_d;
      n_hi_q    <= n_hi_d;
      n_mid_q   <= n_mid_d;
      arm_q     <= arm_d;
    end
  end
endmodule

// File: rtl/acr_commit_regs.sv
module acr_commit_regs
  import acr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lookup_stb,
  input  logic      lut_hit,
  input  acr_pair_t lut_pair,
  input  logic      wr_commit,
  input  acr_pair_t wr_pair,
  input  logic      seq_start,
  output acr_pair_t pair_q,
  output logic      valid_q,
  output logic      uns_q
);
  acr_pair_t pair_d;
  logic take_lut, take_wr, load_en;
  logic cm_q, valid_d, uns_d;

  always_comb begin
    take_lut = lookup_stb && lut_hit;
    take_wr  = wr_commit && !take_lut;
    load_en  = take_lut || take_wr;
    pair_d   = take_lut ? lut_pair : wr_pair;
    uns_d    = uns_q;
    if (load_en) uns_d = 1'b0;
    if (lookup_stb && !lut_hit) uns_d = 1'b1;
    valid_d  = valid_q;
    if (cm_q) valid_d = 1'b1;
    if (seq_start) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      cm_q    <= 1'b0;
      valid_q <= 1'b0;
      uns_q   <= 1'b0;
    end else begin
      if (load_en) pair_q <= pair_d;
      cm_q    <= load_en;
      valid_q <= valid_d;
      uns_q   <= uns_d;
    end
  end
endmodule

// File: rtl/acr_ncts_sel.sv
module acr_ncts_sel
  import acr_pkg::*;
#(
  parameter int FREQ_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] pix_khz,
  input  logic              lookup_stb,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [ACR_W-1:0]  n_out,
  output logic [ACR_W-1:0]  cts_out,
  output logic              valid,
  output logic              unsupported
);
  logic      lut_hit, wr_commit, seq_start;
  acr_pair_t lut_pair, wr_pair, pair_q;

  acr_rate_lut #(.FREQ_W(FREQ_W)) u_lut (
    .pix_khz (pix_khz),
    .hit     (lut_hit),
    .pair    (lut_pair)
  );

  acr_shadow_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_pair   (wr_pair),
    .commit    (wr_commit),
    .seq_start (seq_start)
  );

  acr_commit_regs u_cmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_stb (lookup_stb),
    .lut_hit    (lut_hit),
    .lut_pair   (lut_pair),
    .wr_commit  (wr_commit),
    .wr_pair    (wr_pair),
    .seq_start  (seq_start),
    .pair_q     (pair_q),
    .valid_q    (valid),
    .uns_q      (unsupported)
  );

  assign n_out   = pair_q.n;
  assign cts_out = pair_q.cts;
endmodule

// File: rtl/acr_chk.sv
module acr_chk
  import acr_pkg::*;
#(
  parameter int FREQ_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FREQ_W-1:0] pix_khz,
  input logic              lookup_stb,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [ACR_W-1:0]  n_out,
  input logic [ACR_W-1:0]  cts_out,
  input logic              valid,
  input logic              unsupported
);
  logic miss, lo_wr;
  assign miss  = 32'(pix_khz) > TOP_KHZ;
  assign lo_wr = wr_en && (wr_addr == 3'd5);

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_stb && miss && !lo_wr |=> $stable(n_out) && $stable(cts_out) && unsupported);

  // R6
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_stb && !lo_wr |=> $stable(n_out) && $stable(cts_out));

  // R2
  hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_stb && !miss |=> !unsupported);

  // R8
  seq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd0 |=> !valid);

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(lookup_stb || lo_wr, 2));
endmodule

bind acr_ncts_sel acr_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_khz     (pix_khz),
  .lookup_stb  (lookup_stb),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .n_out       (n_out),
  .cts_out     (cts_out),
  .valid       (valid),
  .unsupported (unsupported)
);

// File: tb/sim_acr_ncts_sel.sv
`timescale 1ns/1ps
module sim_acr_ncts_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] pix_khz;
  logic        lookup_stb, wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [19:0] n_out, cts_out;
  logic        valid, unsupported;

  int n_chk = 0, n_fail = 0;
  int unsigned exp_n = 0, exp_c = 0;
  bit exp_v = 0, exp_u = 0;

  always #2 clk = ~clk;

  acr_ncts_sel u0 (
    .clk(clk), .rst_n(rst_n), .pix_khz(pix_khz), .lookup_stb(lookup_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .n_out(n_out), .cts_out(cts_out), .valid(valid), .unsupported(unsupported)
  );

  function automatic void ref_sel(input int unsigned p, output bit hit,
                                  output int unsigned n, output int unsigned c);
    int unsigned thr [16] = '{25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000,
                              74176, 74250, 83500, 106500, 108000, 148352, 148500, 297000};
    hit = 0; n = 0; c = 0;
    for (int i = 0; i < 16; i++) begin
      if (!hit && p <= thr[i]) begin
        hit = 1; n = 6144; c = thr[i];
        if (thr[i] == 74176)  begin n = 11648; c = 140625; end
        if (thr[i] == 148352) begin n = 5824;  c = 140625; end
        if (thr[i] == 297000) begin n = 5120;  c = 247500; end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_pair(input string tag);
    chk(n_out == 20'(exp_n), {tag, " n"}, n_out, exp_n);
    chk(cts_out == 20'(exp_c), {tag, " cts"}, cts_out, exp_c);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle_valid(input string tag);
    @(negedge clk);
    chk(valid == exp_v, tag, valid, exp_v);
  endtask

  task automatic do_lookup(input int unsigned p);
    bit h; int unsigned n, c;
    ref_sel(p, h, n, c);
    lookup_stb = 1; pix_khz = 20'(p);
    @(negedge clk);
    lookup_stb = 0;
    if (h) begin exp_n = n; exp_c = c; exp_u = 0; end
    else exp_u = 1;
    chk_pair(h ? "R2 R3 lookup" : "R4 miss hold");
    chk(unsupported == exp_u, "R4 unsupported flag", unsupported, exp_u);
    chk(valid == exp_v, "R8 valid not early", valid, exp_v);
    if (h) exp_v = 1;
    idle_valid("R8 valid after lookup");
  endtask

  task automatic man_commit(input int unsigned n, input int unsigned c, input int junk);
    wr(3, 8'h80);
    wr(0, (junk << 4) | int'((c >> 16) & 15));
    exp_v = 0;
    chk(valid == 0, "R8 valid cleared by seq start", valid, 0);
    chk_pair("R6 no early change cts hi");
    wr(1, int'((c >> 8) & 255));
    wr(2, int'(c & 255));
    wr(6, junk * 17);
    wr(3, 8'h80 | int'((n >> 16) & 15));
    wr(7, junk * 5);
    wr(4, int'((n >> 8) & 255));
    chk_pair("R6 R5 no change before low byte");
    wr(5, int'(n & 255));
    exp_n = n & 20'hFFFFF; exp_c = c & 20'hFFFFF; exp_u = 0;
    chk_pair("R6 R5 commit");
    chk(unsupported == 0, "R4 cleared by write commit", unsupported, 0);
    chk(valid == 0, "R8 valid one cycle late", valid, 0);
    exp_v = 1;
    idle_valid("R8 valid after write commit");
  endtask

  task automatic unarmed_low(input int d);
    wr(3, 8'h0F);
    wr(5, d);
    chk_pair("R7 unarmed low write");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned thr [16] = '{25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000,
                              74176, 74250, 83500, 106500, 108000, 148352, 148500, 297000};
    void'($urandom(32'd1234));
    rst_n = 0; lookup_stb = 0; wr_en = 0; wr_addr = 0; wr_data = 0; pix_khz = 0;
    repeat (3) @(negedge clk);
    chk(n_out == 0 && cts_out == 0, "R1 reset pair", n_out, 0);
    chk(valid == 0 && unsupported == 0, "R1 reset flags", {valid, unsupported}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(n_out == 0 && valid == 0, "R1 after release", n_out, 0);

    // directed table corners
    do_lookup(0);
    for (int i = 0; i < 16; i++) begin
      do_lookup(thr[i]);
      do_lookup(thr[i] + 1);
    end
    do_lookup(297001);
    do_lookup(20'hFFFFF);
    man_commit(20'hABCDE, 20'h12345, 15);
    unarmed_low(8'h55);

    // R9 collision: armed low write together with a hitting lookup
    wr(3, 8'h80 | 3);
    wr(4, 8'h11);
    lookup_stb = 1; pix_khz = 20'd74176;
    wr(5, 8'h22);
    lookup_stb = 0;
    exp_n = 11648; exp_c = 140625;
    chk_pair("R9 lookup wins");
    exp_v = 1;
    idle_valid("R9 valid");
    wr(5, 8'h33);
    chk_pair("R9 arm consumed");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned r = $urandom % 5;
      if (r < 2) do_lookup($urandom % 330000);
      else if (r == 2) do_lookup(thr[$urandom % 16] + ($urandom % 3) - 1);
      else if (r == 3) man_commit($urandom, $urandom, int'($urandom % 16));
      else unarmed_low(int'($urandom % 256));
    end

    summary();
  end
endmodule